// File: doc/BRIEF.md
# Idle Insert/Delete Rate Matcher

This stage sits in a 10G Ethernet receive path after block decoding. It takes one 64-bit data word with eight control bits per clock. Each word is handled as two 4-byte lanes. The stage absorbs a clock-rate mismatch of up to ±100 ppm between the far-end transmitter and the local receiver. The two clock domains are modelled here as one clock: `inValid` marks the cycles in which the remote side delivers a word, and `outReady` marks the cycles in which the local side takes one. A single-clock FIFO sits between the two.

When the FIFO runs low, the stage makes up the shortfall by emitting a word of eight Idles. It does this only straight after an Idle or an ordered set has gone out. When the FIFO runs high, it drops one lane of four Idles, or one lane holding a repeated sequence ordered set. Which lane it may drop depends on where a Terminate sits in the current word or in the word before it. After a drop, the next lane is repacked behind the survivor, so every word written to the FIFO stays full.

Top module: `idle_rate_matcher`

## Requirements
- R1: While reset is held, and after it is released until the first `outReady`, `outValid` is low and the FIFO is empty.
- R2: Words that are neither dropped nor repacked leave in the order they arrived. One word leaves per `outReady` cycle, and `outValid` rises in the cycle after `outReady` is sampled. `outValid` is low one cycle after `outReady` is low.
- R3: Lane 0 is data bits 31:0 with control bits 3:0, and lane 1 is data bits 63:32 with control bits 7:4. Byte j uses data bits 8j+7:8j and control bit j. An Idle is byte 0x07 with its control bit set. A Terminate is 0xFD with its control bit set. An ordered-set lane has 0x9C with its control bit set in the lane's lowest byte.
- R4: An Idle word is emitted (data 0x0707070707070707, control 0xFF), and the FIFO is not read, when all three of these hold: `outReady` is high, the fill is below `LOW_MARK`, and the last word emitted had lane 1 either all Idles or an ordered set.
- R5: If the last word emitted had any other lane 1 and the FIFO is empty, `outValid` stays low on `outReady`.
- R6: With the fill at or above `HIGH_MARK`, an incoming lane 0 of four Idles is dropped if lane 1 of the same word holds no Terminate.
- R7: With the fill at or above `HIGH_MARK`, an incoming lane 1 of four Idles is dropped only if lane 0 of the previous input word held no Terminate.
- R8: With the fill at or above `HIGH_MARK`, an ordered-set lane is dropped only when the lane just before it in the input stream (same word or previous word) was also an ordered set. Only the second of the two is dropped.
- R9: After a drop, the surviving lane is held back. It is written as lane 0 of the next FIFO word, with the following input lane as lane 1. Lanes keep their stream order.
- R10: At most one lane is dropped per input word. Priority runs: Idle lane 0, Idle lane 1, ordered-set lane 0, ordered-set lane 1. A drop never happens in a cycle that inserts an Idle word.
- R11: After reset, the last emitted word is treated as Idles, so an `outReady` with a low FIFO produces an Idle word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Remote side delivers a word this cycle |
| inData | input | 64 | Incoming data, two 4-byte lanes |
| inCtrl | input | 8 | Incoming control bit per byte |
| outReady | input | 1 | Local side takes a word this cycle |
| outValid | output | 1 | Output word is valid |
| outData | output | 64 | Outgoing data |
| outCtrl | output | 8 | Outgoing control bits |

## Verification
The bench fills the FIFO to the high mark with numbered data words. It then offers one special word at a time: an Idle lane 0, an Idle lane 1, an Idle lane 1 behind a Terminate, an Idle lane 0 with a Terminate in lane 1, an ordered-set pair inside one word, and an ordered-set pair across two words. It then drains the FIFO and compares every emitted word against a sequence worked out by hand.

Some designs would get the Terminate rules wrong. One that drops a lane against those rules, or keeps a lane it should drop, changes both the word count and the word that follows in the drain. One that repacks in the wrong lane order shows swapped halves. One that inserts an Idle word after a data word would give out Idles where the bench expects `outValid` low. One that never inserts after an ordered set would pop a word where the bench expects an Idle word.

// File: rtl/rm_pkg.sv
package rm_pkg;

  localparam logic [7:0] IDLE_CODE = 8'h07;
  localparam logic [7:0] TERM_CODE = 8'hFD;
  localparam logic [7:0] SEQ_CODE  = 8'h9C;
  localparam logic [63:0] IDLE_WORD = {8{IDLE_CODE}};

  typedef struct packed {
    logic dropIdleLo;
    logic dropIdleHi;
    logic dropSeqLo;
    logic dropSeqHi;
    logic insIdle;
    logic pop;
  } rm_strobe_t;

  function automatic logic laneAllIdle(input logic [31:0] d, input logic [3:0] c);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < 4; b++)
      if (!(c[b] && d[8*b +: 8] == IDLE_CODE)) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic laneHasTerm(input logic [31:0] d, input logic [3:0] c);
    logic hit;
    hit = 1'b0;
    for (int b = 0; b < 4; b++)
      if (c[b] && d[8*b +: 8] == TERM_CODE) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic laneIsSeq(input logic [31:0] d, input logic [3:0] c);
    return c[0] && d[7:0] == SEQ_CODE;
  endfunction

endpackage

// File: rtl/rm_ctrl.sv
module rm_ctrl
  import rm_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int LOW_MARK  = 2,
  parameter int HIGH_MARK = 6,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          inValid,
  input  logic [63:0]   inData,
  input  logic [7:0]    inCtrl,
  input  logic          outReady,
  input  logic [CW-1:0] fillCount,
  input  logic          prevLowTerm,
  input  logic          prevHighSeq,
  input  logic          lastOutOk,
  output rm_strobe_t    strb
);

  logic [1:0] laneIdle, laneTerm, laneSeq;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign laneIdle[i] = laneAllIdle(inData[32*i +: 32], inCtrl[4*i +: 4]);
    assign laneTerm[i] = laneHasTerm(inData[32*i +: 32], inCtrl[4*i +: 4]);
    assign laneSeq[i]  = laneIsSeq(inData[32*i +: 32], inCtrl[4*i +: 4]);
  end

  logic aboveHigh, belowLow;
  assign aboveHigh = fillCount >= CW'(HIGH_MARK);
  assign belowLow  = fillCount <  CW'(LOW_MARK);

  always_comb begin
    strb = '0;
    if (inValid && aboveHigh) begin
      if (laneIdle[0] && !laneTerm[1])      strb.dropIdleLo = 1'b1;
      else if (laneIdle[1] && !prevLowTerm) strb.dropIdleHi = 1'b1;
      else if (laneSeq[0] && prevHighSeq)   strb.dropSeqLo  = 1'b1;
      else if (laneSeq[1] && laneSeq[0])    strb.dropSeqHi  = 1'b1;
    end
    strb.insIdle = outReady && belowLow && lastOutOk;
    strb.pop     = outReady && !strb.insIdle && fillCount != '0;
  end

endmodule

// File: rtl/rm_datapath.sv
module rm_datapath
  import rm_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int WW = 72
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [63:0]   inData,
  input  logic [7:0]    inCtrl,
  input  rm_strobe_t    strb,
  output logic [CW-1:0] fillCount,
  output logic          prevLowTerm,
  output logic          prevHighSeq,
  output logic          lastOutOk,
  output logic          outValid,
  output logic [63:0]   outData,
  output logic [7:0]    outCtrl
);

  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          pendValid;
  logic [35:0]   pendLane;

  logic [35:0] lane0, lane1, survivor;
  assign lane0 = {inCtrl[3:0], inData[31:0]};
  assign lane1 = {inCtrl[7:4], inData[63:32]};

  logic dropAny;
  assign dropAny  = strb.dropIdleLo | strb.dropIdleHi | strb.dropSeqLo | strb.dropSeqHi;
  assign survivor = (strb.dropIdleLo | strb.dropSeqLo) ? lane1 : lane0;

  logic        wrEn;
  logic [35:0] wrLo, wrHi;
  always_comb begin
    if (dropAny) begin
      wrEn = pendValid;
      wrLo = pendLane;
      wrHi = survivor;
    end else begin
      wrEn = inValid;
      wrLo = pendValid ? pendLane : lane0;
      wrHi = pendValid ? lane0 : lane1;
    end
  end

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (wrEn) mem[wrPtr] <= {wrHi[35:32], wrLo[35:32], wrHi[31:0], wrLo[31:0]};

  logic [WW-1:0] head;
  assign head = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      fillCount   <= '0;
      pendValid   <= 1'b0;
      pendLane    <= '0;
      prevLowTerm <= 1'b0;
      prevHighSeq <= 1'b0;
      lastOutOk   <= 1'b1;
      outValid    <= 1'b0;
      outData     <= '0;
      outCtrl     <= '0;
    end else begin
      if (wrEn)     wrPtr <= stepPtr(wrPtr);
      if (strb.pop) rdPtr <= stepPtr(rdPtr);
      case ({wrEn, strb.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase

      if (dropAny) begin
        pendValid <= !pendValid;
        if (!pendValid) pendLane <= survivor;
      end else if (inValid && pendValid) begin
        pendLane <= lane1;
      end

      if (inValid) begin
        prevLowTerm <= laneHasTerm(lane0[31:0], lane0[35:32]);
        prevHighSeq <= laneIsSeq(lane1[31:0], lane1[35:32]);
      end

      outValid <= strb.insIdle | strb.pop;
      if (strb.insIdle) begin
        outData   <= IDLE_WORD;
        outCtrl   <= 8'hFF;
        lastOutOk <= 1'b1;
      end else if (strb.pop) begin
        outData   <= head[63:0];
        outCtrl   <= head[71:64];
        lastOutOk <= laneAllIdle(head[63:32], head[71:68]) | laneIsSeq(head[63:32], head[71:68]);
      end
    end
  end

endmodule

// File: rtl/idle_rate_matcher.sv
module idle_rate_matcher
  import rm_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int LOW_MARK  = 2,
  parameter int HIGH_MARK = 6,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [63:0] inData,
  input  logic [7:0]  inCtrl,
  input  logic        outReady,
  output logic        outValid,
  output logic [63:0] outData,
  output logic [7:0]  outCtrl
);

  rm_strobe_t    strb;
  logic [CW-1:0] fillCount;
  logic          prevLowTerm, prevHighSeq, lastOutOk;

  rm_ctrl #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) uCtrl (
    .inValid(inValid), .inData(inData), .inCtrl(inCtrl), .outReady(outReady),
    .fillCount(fillCount), .prevLowTerm(prevLowTerm), .prevHighSeq(prevHighSeq),
    .lastOutOk(lastOutOk), .strb(strb)
  );

  rm_datapath #(.DEPTH(DEPTH)) uPath (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inCtrl(inCtrl),
    .strb(strb), .fillCount(fillCount), .prevLowTerm(prevLowTerm),
    .prevHighSeq(prevHighSeq), .lastOutOk(lastOutOk),
    .outValid(outValid), .outData(outData), .outCtrl(outCtrl)
  );

endmodule

// File: rtl/rm_checker.sv
module rm_checker
  import rm_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int LOW_MARK  = 2,
  parameter int HIGH_MARK = 6,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          outReady,
  input logic          outValid,
  input logic [63:0]   outData,
  input logic [7:0]    outCtrl,
  input rm_strobe_t    strb,
  input logic [CW-1:0] fillCount
);

  logic [3:0] drops;
  assign drops = {strb.dropIdleLo, strb.dropIdleHi, strb.dropSeqLo, strb.dropSeqHi};

  a_r4_insert_word: assert property (@(posedge clk) disable iff (!rstN)
    strb.insIdle |=> outValid && outData == IDLE_WORD && outCtrl == 8'hFF);

  a_r4_insert_only_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.insIdle |-> fillCount < CW'(LOW_MARK));

  a_r10_one_lane: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(drops));

  a_r10_no_mix: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.insIdle && drops != '0));

  a_r10_drop_only_high: assert property (@(posedge clk) disable iff (!rstN)
    drops != '0 |-> fillCount >= CW'(HIGH_MARK));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH));

  a_r2_quiet_output: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |=> !outValid);

endmodule

bind idle_rate_matcher rm_checker #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) uChk (
  .clk(clk), .rstN(rstN), .outReady(outReady), .outValid(outValid),
  .outData(outData), .outCtrl(outCtrl), .strb(strb), .fillCount(fillCount)
);

// File: tb/idle_rate_matcher_test.sv
`timescale 1ns/1ps
module idle_rate_matcher_test;

  localparam logic [31:0] IL = 32'h07070707;
  localparam logic [31:0] TL = 32'h070707FD;
  localparam logic [31:0] SL = 32'h0100009C;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, outReady = 1'b0;
  logic [63:0] inData = '0;
  logic [7:0]  inCtrl = '0;
  logic        outValid;
  logic [63:0] outData;
  logic [7:0]  outCtrl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  idle_rate_matcher uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inCtrl(inCtrl),
    .outReady(outReady), .outValid(outValid), .outData(outData), .outCtrl(outCtrl)
  );

  function automatic logic [31:0] lo(input int k); return 32'h5A000000 | (2*k);     endfunction
  function automatic logic [31:0] hi(input int k); return 32'h5A000000 | (2*k + 1); endfunction
  function automatic logic [63:0] dw(input int k); return {hi(k), lo(k)};          endfunction

  task automatic doReset();
    @(negedge clk); rstN = 0; inValid = 0; outReady = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic push(input logic [63:0] d, input logic [7:0] c);
    @(negedge clk); inValid = 1; inData = d; inCtrl = c;
    @(negedge clk); inValid = 0;
  endtask

  task automatic pushData(input int n);
    for (int k = 0; k < n; k++) push(dw(k), 8'h00);
  endtask

  task automatic pull(input string tag, input logic ev, input logic [63:0] ed, input logic [7:0] ec);
    @(negedge clk); outReady = 1;
    @(negedge clk); outReady = 0;
    checks++;
    if (outValid !== ev || (ev && (outData !== ed || outCtrl !== ec))) begin
      errors++;
      $display("FAIL %s: got v=%0b d=%h c=%h, expected v=%0b d=%h c=%h",
               tag, outValid, outData, outCtrl, ev, ed, ec);
    end
  endtask

  task automatic pullData(input string tag, input int n);
    for (int k = 0; k < n; k++) pull(tag, 1'b1, dw(k), 8'h00);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    doReset();
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      errors++; $display("FAIL R1: got outValid=%0b expected 0", outValid);
    end
    // R11 and R4: empty after reset gives Idle word
    pull("R11", 1'b1, {2{IL}}, 8'hFF);

    // R2 and R5: order kept, no insertion after data
    doReset();
    pushData(4);
    pullData("R2", 4);
    pull("R5", 1'b0, '0, '0);

    // R6 and R9: Idle lane 0 dropped, repack
    doReset();
    pushData(6);
    push({IL, IL}, 8'hFF);
    push(dw(20), 8'h00);
    push(dw(21), 8'h00);
    pullData("R6", 6);
    pull("R9", 1'b1, {lo(20), IL}, 8'h0F);
    pull("R9", 1'b1, {lo(21), hi(20)}, 8'h00);

    // R7: Idle lane 1 dropped
    doReset();
    pushData(6);
    push({IL, lo(30)}, 8'hF0);
    push(dw(31), 8'h00);
    pullData("R7", 6);
    pull("R7", 1'b1, {lo(31), lo(30)}, 8'h00);

    // R7: Terminate in previous lane 0 blocks drop; R4 insertion after Idle lane
    doReset();
    pushData(5);
    push({IL, TL}, 8'hFF);
    push({IL, lo(40)}, 8'hF0);
    push(dw(41), 8'h00);
    pullData("R7_term", 5);
    pull("R7_term", 1'b1, {IL, TL}, 8'hFF);
    pull("R7_term", 1'b1, {IL, lo(40)}, 8'hF0);
    pull("R4", 1'b1, {2{IL}}, 8'hFF);

    // R6: Terminate in lane 1 blocks drop of lane 0; R5 after it
    doReset();
    pushData(6);
    push({TL, IL}, 8'hFF);
    pullData("R6_term", 6);
    pull("R6_term", 1'b1, {TL, IL}, 8'hFF);
    pull("R5", 1'b0, '0, '0);

    // R8: ordered-set pair inside one word
    doReset();
    pushData(6);
    push({SL, SL}, 8'h11);
    push(dw(50), 8'h00);
    pullData("R8", 6);
    pull("R8", 1'b1, {lo(50), SL}, 8'h01);

    // R8 and R10: ordered-set pair across words; R4 insertion after ordered set
    doReset();
    pushData(5);
    push({SL, lo(60)}, 8'h10);
    push({SL, SL}, 8'h11);
    push(dw(61), 8'h00);
    pullData("R8_cross", 5);
    pull("R8_cross", 1'b1, {SL, lo(60)}, 8'h10);
    pull("R4", 1'b1, {2{IL}}, 8'hFF);

    // R10: below the high mark nothing is dropped
    doReset();
    pushData(2);
    push({IL, IL}, 8'hFF);
    pullData("R10", 2);
    pull("R10", 1'b1, {IL, IL}, 8'hFF);

    // R2 and R3: mixed control bits pass unchanged
    doReset();
    pushData(2);
    push({hi(70), TL}, 8'h0F);
    push(dw(71), 8'h00);
    pullData("R3", 2);
    pull("R3", 1'b1, {hi(70), TL}, 8'h0F);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule